// File: doc/BRIEF.md
# Bankset Lookup Sequencer

This block steers a single lookup through a banked last-level cache whose banks sit on an on-chip mesh. A bankset has sixteen member banks, and each one holds one way of the set. Eight of them are near the cores, one per core. The other eight sit in the middle of the mesh. When a core issues a request, the sequencer first probes the bank local to that core together with every central bank. It probes the other seven near-core banks only if all of the first nine replies are misses. It collects one reply from each probed bank, in any order, and then reports one of two outcomes. On a hit it names the bank that hit and orders the block one grid step toward the requester. On a miss it forwards the aligned block address to off-chip memory and names the bank where the fill will land.

The banks are arranged on a two-row grid. Row 0 holds the near-core banks 0 to N-1, and bank `c` is local to core `c`. Row 1 holds the central banks N to 2N-1, and central bank `N+j` sits in column `j`. The requester is at row 0, column `c`. One step of promotion closes the column gap first and only then changes row. Only one request is in flight at a time, and `req_ready` stalls the requester while a lookup runs.

Top module: `bankset_search_seq`

## Requirements
- R1: After reset, `req_ready` is 1 and `probe_valid`, `done_valid`, `mig_valid`, `miss_valid` and `proto_err` are 0.
- R2: A request is taken only in a cycle where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from the cycle after acceptance until the result cycle. A request presented while `req_ready` is 0 has no effect on the lookup in progress.
- R3: In the cycle after acceptance, `probe_valid` pulses for exactly one cycle. The pulse covers bank `req_core` and banks 8 to 15. At the same time, `probe_set` carries address bits [11:6], which are the bankset index just above the 64-byte block offset.
- R4: A phase ends only in the cycle after one reply has been taken from every bank probed in that phase. Replies may arrive in any order and several may arrive in one cycle. A reply from a bank that was not probed is ignored, and so is a repeated reply from a bank that has already answered.
- R5: If every first-phase reply is a miss, `probe_valid` pulses in the cycle after the last reply for the seven near-core banks other than `req_core`.
- R6: When a phase contains a hit, `done_valid` pulses for one cycle in the cycle after that phase's last reply, with `done_hit`=1 and `done_bank` set to the bank that hit. No later phase is probed.
- R7: If more than one bank hits in the same phase, `done_bank` is the lowest-numbered of them and `proto_err` is 1 together with `done_valid`.
- R8: On a hit, `mig_valid` is 1 with `mig_src`=`done_bank` when the block is not already in the requester's local bank. `mig_dst` is the neighbour one column closer to the requester in the same row. If the column already matches, `mig_dst` is the requester's local bank. A hit in the requester's local bank gives `mig_valid`=0.
- R9: If all sixteen banks miss, `done_valid` pulses with `done_hit`=0 and `miss_valid`=1. `miss_addr` is the request address with bits [5:0] cleared, and `miss_fill_bank` is address bits [15:12].
- R10: `req_ready` is 1 in the same cycle that `done_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_core | input | 3 | Requesting core number |
| req_addr | input | 32 | Byte address of the request |
| probe_valid | output | 16 | One-cycle lookup probe, one bit per bank |
| probe_set | output | 6 | Bankset index sent with the probes |
| rsp_valid | input | 16 | Reply strobe, one bit per bank |
| rsp_hit | input | 16 | Reply result per bank, 1 for hit |
| done_valid | output | 1 | One-cycle result strobe |
| done_hit | output | 1 | Result was a hit |
| done_bank | output | 4 | Bank that hit |
| proto_err | output | 1 | More than one bank hit in the deciding phase |
| mig_valid | output | 1 | Promotion command present |
| mig_src | output | 4 | Bank the block leaves |
| mig_dst | output | 4 | Bank the block moves to |
| miss_valid | output | 1 | Off-chip request strobe |
| miss_addr | output | 32 | Block-aligned address for off-chip fetch |
| miss_fill_bank | output | 4 | Bank chosen to receive the fill |

## Verification
The checker assumes that each bank answers a probe only while the probe is outstanding, and that no reply arrives for a lookup that has already ended. It also assumes `req_core` and `req_addr` are stable only in the acceptance cycle. The bench models the banks as a loop that answers only the bits it saw in `probe_valid`, so it never replies to a lookup that has ended. Deliberate stray replies from unprobed banks and repeated replies are confined to a phase that is still waiting. They check that such replies change nothing.

// File: rtl/bss_pkg.sv
package bss_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_NEAR = 2'd1,
      ST_FAR  = 2'd2
   } bss_state_t;

endpackage

// File: rtl/bss_phase_masks.sv
module bss_phase_masks #(
   parameter int NUM_LOCAL   = 8,
   parameter int NUM_CENTRAL = 8,
   parameter int CORE_W      = 3,
   localparam int NB         = NUM_LOCAL + NUM_CENTRAL
) (
   input  logic [CORE_W-1:0] core,
   output logic [NB-1:0]     first_mask,
   output logic [NB-1:0]     second_mask
);

   for (genvar i = 0; i < NUM_LOCAL; i++) begin : g_local
      assign first_mask[i]  = (core == CORE_W'(i));
      assign second_mask[i] = (core != CORE_W'(i));
   end

   for (genvar j = 0; j < NUM_CENTRAL; j++) begin : g_central
      assign first_mask[NUM_LOCAL+j]  = 1'b1;
      assign second_mask[NUM_LOCAL+j] = 1'b0;
   end

endmodule

// File: rtl/bss_hit_pick.sv
module bss_hit_pick #(
   parameter int N     = 16,
   parameter int IDX_W = 4
) (
   input  logic [N-1:0]     hits,
   output logic             any_hit,
   output logic             multi_hit,
   output logic [IDX_W-1:0] idx
);

   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (hits[i]) idx = IDX_W'(i);
      end
   end

   assign any_hit   = |hits;
   assign multi_hit = |(hits & (hits - N'(1)));

endmodule

// File: rtl/bss_promote.sv
module bss_promote #(
   parameter int NUM_LOCAL = 8,
   parameter int BANK_W    = 4,
   parameter int CORE_W    = 3
) (
   input  logic [BANK_W-1:0] bank,
   input  logic [CORE_W-1:0] core,
   output logic              move,
   output logic [BANK_W-1:0] dst
);

   localparam logic [BANK_W-1:0] ROW_OFS = BANK_W'(NUM_LOCAL);

   logic              central;
   logic [BANK_W-1:0] col;
   logic [BANK_W-1:0] goal;

   assign central = (bank >= ROW_OFS);
   assign col     = central ? (bank - ROW_OFS) : bank;
   assign goal    = BANK_W'(core);

   always_comb begin
      move = 1'b1;
      dst  = bank;
      if (col < goal) begin
         dst = bank + BANK_W'(1);
      end else if (col > goal) begin
         dst = bank - BANK_W'(1);
      end else if (central) begin
         dst = col;
      end else begin
         move = 1'b0;
      end
   end

endmodule

// File: rtl/bankset_search_seq.sv
module bankset_search_seq
   import bss_pkg::*;
#(
   parameter int NUM_LOCAL   = 8,
   parameter int NUM_CENTRAL = 8,
   parameter int ADDR_W      = 32,
   parameter int OFFSET_W    = 6,
   parameter int SET_W       = 6,
   localparam int NB         = NUM_LOCAL + NUM_CENTRAL,
   localparam int BANK_W     = $clog2(NB),
   localparam int CORE_W     = $clog2(NUM_LOCAL)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [CORE_W-1:0] req_core,
   input  logic [ADDR_W-1:0] req_addr,
   output logic [NB-1:0]     probe_valid,
   output logic [SET_W-1:0]  probe_set,
   input  logic [NB-1:0]     rsp_valid,
   input  logic [NB-1:0]     rsp_hit,
   output logic              done_valid,
   output logic              done_hit,
   output logic [BANK_W-1:0] done_bank,
   output logic              proto_err,
   output logic              mig_valid,
   output logic [BANK_W-1:0] mig_src,
   output logic [BANK_W-1:0] mig_dst,
   output logic              miss_valid,
   output logic [ADDR_W-1:0] miss_addr,
   output logic [BANK_W-1:0] miss_fill_bank
);

   if (NUM_LOCAL < 2) begin : g_bad_local
      $error("NUM_LOCAL must be at least 2");
   end
   if (NUM_CENTRAL != NUM_LOCAL) begin : g_bad_grid
      $error("grid needs one central bank per column");
   end
   if (ADDR_W < OFFSET_W + SET_W + BANK_W) begin : g_bad_addr
      $error("address too narrow for offset, set and fill-bank fields");
   end

   bss_state_t        state;
   logic [CORE_W-1:0] core_q;
   logic [ADDR_W-1:0] addr_q;
   logic [NB-1:0]     pending;
   logic [NB-1:0]     hits;
   logic [NB-1:0]     probe_q;
   logic              done_q, hit_q, err_q, mig_q, miss_q;
   logic [BANK_W-1:0] bank_q, dst_q;

   logic [CORE_W-1:0] core_sel;
   logic [NB-1:0]     first_mask, second_mask;
   logic [NB-1:0]     live, pend_nx, hits_nx;
   logic              phase_end, any_hit, multi_hit, move;
   logic [BANK_W-1:0] win_bank, step_dst;

   assign core_sel = (state == ST_IDLE) ? req_core : core_q;

   bss_phase_masks #(
      .NUM_LOCAL  (NUM_LOCAL),
      .NUM_CENTRAL(NUM_CENTRAL),
      .CORE_W     (CORE_W)
   ) u_masks (
      .core       (core_sel),
      .first_mask (first_mask),
      .second_mask(second_mask)
   );

   assign live      = rsp_valid & pending;
   assign pend_nx   = pending & ~live;
   assign hits_nx   = hits | (live & rsp_hit);
   assign phase_end = (state != ST_IDLE) && (pend_nx == '0);

   bss_hit_pick #(
      .N    (NB),
      .IDX_W(BANK_W)
   ) u_pick (
      .hits     (hits_nx),
      .any_hit  (any_hit),
      .multi_hit(multi_hit),
      .idx      (win_bank)
   );

   bss_promote #(
      .NUM_LOCAL(NUM_LOCAL),
      .BANK_W   (BANK_W),
      .CORE_W   (CORE_W)
   ) u_promote (
      .bank(win_bank),
      .core(core_q),
      .move(move),
      .dst (step_dst)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         core_q  <= '0;
         addr_q  <= '0;
         pending <= '0;
         hits    <= '0;
         probe_q <= '0;
         done_q  <= 1'b0;
         hit_q   <= 1'b0;
         err_q   <= 1'b0;
         mig_q   <= 1'b0;
         miss_q  <= 1'b0;
         bank_q  <= '0;
         dst_q   <= '0;
      end else begin
         probe_q <= '0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
         mig_q   <= 1'b0;
         miss_q  <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  core_q  <= req_core;
                  addr_q  <= {req_addr[ADDR_W-1:OFFSET_W], {OFFSET_W{1'b0}}};
                  probe_q <= first_mask;
                  pending <= first_mask;
                  hits    <= '0;
                  state   <= ST_NEAR;
               end
            end
            default: begin
               pending <= pend_nx;
               hits    <= hits_nx;
               if (phase_end) begin
                  if (any_hit) begin
                     done_q <= 1'b1;
                     hit_q  <= 1'b1;
                     bank_q <= win_bank;
                     err_q  <= multi_hit;
                     mig_q  <= move;
                     dst_q  <= step_dst;
                     state  <= ST_IDLE;
                  end else if (state == ST_NEAR) begin
                     probe_q <= second_mask;
                     pending <= second_mask;
                     hits    <= '0;
                     state   <= ST_FAR;
                  end else begin
                     done_q <= 1'b1;
                     hit_q  <= 1'b0;
                     miss_q <= 1'b1;
                     state  <= ST_IDLE;
                  end
               end
            end
         endcase
      end
   end

   assign req_ready      = (state == ST_IDLE);
   assign probe_valid    = probe_q;
   assign probe_set      = addr_q[OFFSET_W +: SET_W];
   assign done_valid     = done_q;
   assign done_hit       = hit_q;
   assign done_bank      = bank_q;
   assign proto_err      = err_q;
   assign mig_valid      = mig_q;
   assign mig_src        = bank_q;
   assign mig_dst        = dst_q;
   assign miss_valid     = miss_q;
   assign miss_addr      = addr_q;
   assign miss_fill_bank = addr_q[OFFSET_W+SET_W +: BANK_W];

endmodule

// File: rtl/bss_search_checker.sv
module bss_search_checker #(
   parameter int NB     = 16,
   parameter int BANK_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic [NB-1:0]     probe_valid,
   input logic              done_valid,
   input logic              done_hit,
   input logic              proto_err,
   input logic              mig_valid,
   input logic [BANK_W-1:0] mig_src,
   input logic [BANK_W-1:0] mig_dst,
   input logic              miss_valid
);

   AST_ACCEPT_PROBES: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (probe_valid != '0)); // R3

   AST_BUSY_WHILE_PROBING: assert property (@(posedge clk) disable iff (!rst_n)
      (probe_valid != '0) |-> !req_ready); // R2

   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |=> !done_valid); // R6

   AST_ERR_ONLY_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      proto_err |-> (done_valid && done_hit)); // R7

   AST_MIG_ONLY_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      mig_valid |-> (done_valid && done_hit)); // R8

   AST_MIG_CHANGES_BANK: assert property (@(posedge clk) disable iff (!rst_n)
      mig_valid |-> (mig_dst != mig_src)); // R8

   AST_MISS_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      miss_valid |-> (done_valid && !done_hit)); // R9

   AST_READY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |-> req_ready); // R10

endmodule

bind bankset_search_seq bss_search_checker #(
   .NB    (NB),
   .BANK_W(BANK_W)
) u_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .probe_valid(probe_valid),
   .done_valid (done_valid),
   .done_hit   (done_hit),
   .proto_err  (proto_err),
   .mig_valid  (mig_valid),
   .mig_src    (mig_src),
   .mig_dst    (mig_dst),
   .miss_valid (miss_valid)
);

// File: tb/bankset_search_seq_tb_top.sv
module bankset_search_seq_tb_top;

   localparam int NB = 16;
   localparam int NV = 10;

   typedef struct packed {
      logic [2:0]  core;
      logic [31:0] addr;
      logic [15:0] hitmask;
      logic        desc;
      logic        e_hit;
      logic [3:0]  e_bank;
      logic        e_err;
      logic        e_mig;
      logic [3:0]  e_dst;
   } vec_t;

   localparam vec_t VECS [NV] = '{
      '{3'd3, 32'h0001_0040, 16'h0008, 1'b0, 1'b1, 4'd3,  1'b0, 1'b0, 4'd0},
      '{3'd3, 32'h0002_0080, 16'h0800, 1'b1, 1'b1, 4'd11, 1'b0, 1'b1, 4'd3},
      '{3'd3, 32'h0003_00C0, 16'h0100, 1'b0, 1'b1, 4'd8,  1'b0, 1'b1, 4'd9},
      '{3'd2, 32'h0004_1000, 16'h8000, 1'b1, 1'b1, 4'd15, 1'b0, 1'b1, 4'd14},
      '{3'd0, 32'h0005_2040, 16'h0020, 1'b0, 1'b1, 4'd5,  1'b0, 1'b1, 4'd4},
      '{3'd7, 32'h0006_3080, 16'h0001, 1'b1, 1'b1, 4'd0,  1'b0, 1'b1, 4'd1},
      '{3'd5, 32'h0000_A5C7, 16'h0000, 1'b0, 1'b0, 4'd0,  1'b0, 1'b0, 4'd0},
      '{3'd1, 32'h0007_0100, 16'h1200, 1'b1, 1'b1, 4'd9,  1'b1, 1'b1, 4'd1},
      '{3'd4, 32'h0008_0140, 16'h0044, 1'b0, 1'b1, 4'd2,  1'b1, 1'b1, 4'd3},
      '{3'd6, 32'h0009_0180, 16'h0044, 1'b1, 1'b1, 4'd6,  1'b0, 1'b0, 4'd0}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [2:0]    req_core = '0;
   logic [31:0]   req_addr = '0;
   logic [NB-1:0] probe_valid;
   logic [5:0]    probe_set;
   logic [NB-1:0] rsp_valid = '0;
   logic [NB-1:0] rsp_hit = '0;
   logic          done_valid, done_hit, proto_err, mig_valid, miss_valid;
   logic [3:0]    done_bank, mig_src, mig_dst, miss_fill_bank;
   logic [31:0]   miss_addr;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   bankset_search_seq dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .req_ready     (req_ready),
      .req_core      (req_core),
      .req_addr      (req_addr),
      .probe_valid   (probe_valid),
      .probe_set     (probe_set),
      .rsp_valid     (rsp_valid),
      .rsp_hit       (rsp_hit),
      .done_valid    (done_valid),
      .done_hit      (done_hit),
      .done_bank     (done_bank),
      .proto_err     (proto_err),
      .mig_valid     (mig_valid),
      .mig_src       (mig_src),
      .mig_dst       (mig_dst),
      .miss_valid    (miss_valid),
      .miss_addr     (miss_addr),
      .miss_fill_bank(miss_fill_bank)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic answer_phase(input logic [NB-1:0] mask, input logic [NB-1:0] hm,
                               input bit desc);
      int left = $countones(mask);
      for (int k = 0; k < NB; k++) begin
         int b = desc ? (NB - 1 - k) : k;
         if (mask[b]) begin
            rsp_valid = NB'(1) << b;
            rsp_hit   = hm[b] ? rsp_valid : '0;
            @(negedge clk);
            rsp_valid = '0;
            rsp_hit   = '0;
            left--;
            if (left > 0) begin
               chk("R4 no early done", 64'(done_valid), 64'd0);
               chk("R4 no early probe", 64'(probe_valid), 64'd0);
            end
         end
      end
   endtask

   task automatic run_vec(input vec_t v);
      logic [NB-1:0] p1, p2;
      p1 = (NB'(1) << v.core) | 16'hFF00;
      p2 = 16'h00FF & ~(NB'(1) << v.core);
      @(negedge clk);
      req_valid = 1'b1;
      req_core  = v.core;
      req_addr  = v.addr;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R3 first probe mask", 64'(probe_valid), 64'(p1));
      chk("R3 probe set", 64'(probe_set), 64'((v.addr >> 6) & 32'h3F));
      chk("R2 busy", 64'(req_ready), 64'd0);
      answer_phase(p1, v.hitmask, v.desc);
      if ((v.hitmask & p1) == '0) begin
         chk("R5 second probe mask", 64'(probe_valid), 64'(p2));
         chk("R5 no done yet", 64'(done_valid), 64'd0);
         answer_phase(p2, v.hitmask, v.desc);
      end
      chk("R6 done", 64'(done_valid), 64'd1);
      chk("R6 hit flag", 64'(done_hit), 64'(v.e_hit));
      chk("R10 ready at done", 64'(req_ready), 64'd1);
      chk("R6 no stray probe", 64'(probe_valid), 64'd0);
      if (v.e_hit) begin
         chk("R6 bank", 64'(done_bank), 64'(v.e_bank));
         chk("R7 error flag", 64'(proto_err), 64'(v.e_err));
         chk("R8 mig valid", 64'(mig_valid), 64'(v.e_mig));
         chk("R9 no miss on hit", 64'(miss_valid), 64'd0);
         if (v.e_mig) begin
            chk("R8 mig src", 64'(mig_src), 64'(v.e_bank));
            chk("R8 mig dst", 64'(mig_dst), 64'(v.e_dst));
         end
      end else begin
         chk("R9 miss valid", 64'(miss_valid), 64'd1);
         chk("R9 miss addr", 64'(miss_addr), 64'(v.addr & 32'hFFFF_FFC0));
         chk("R9 fill bank", 64'(miss_fill_bank), 64'((v.addr >> 12) & 32'hF));
         chk("R8 no mig on miss", 64'(mig_valid), 64'd0);
      end
      @(negedge clk);
      chk("R6 done is a pulse", 64'(done_valid), 64'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 ready", 64'(req_ready), 64'd1);
      chk("R1 probe", 64'(probe_valid), 64'd0);
      chk("R1 done", 64'(done_valid), 64'd0);
      chk("R1 mig", 64'(mig_valid), 64'd0);
      chk("R1 miss", 64'(miss_valid), 64'd0);
      chk("R1 err", 64'(proto_err), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 ready after release", 64'(req_ready), 64'd1);

      for (int i = 0; i < NV; i++) run_vec(VECS[i]);

      // Directed: busy request, stray and repeated replies, simultaneous replies
      @(negedge clk);
      req_valid = 1'b1;
      req_core  = 3'd3;
      req_addr  = 32'h000A_0200;
      @(negedge clk);
      chk("R3 directed probe", 64'(probe_valid), 64'h0000_FF08);
      req_core  = 3'd0;
      rsp_valid = 16'h0001;
      rsp_hit   = 16'h0001;
      @(negedge clk);
      chk("R2 ready low while busy", 64'(req_ready), 64'd0);
      chk("R4 stray reply ignored", 64'(done_valid), 64'd0);
      rsp_valid = 16'h0100;
      rsp_hit   = '0;
      @(negedge clk);
      @(negedge clk);
      chk("R4 repeat reply not counted", 64'(done_valid | (probe_valid != '0)), 64'd0);
      rsp_valid = 16'hFE08;
      @(negedge clk);
      rsp_valid = '0;
      chk("R5 after simultaneous replies", 64'(probe_valid), 64'h0000_00F7);
      chk("R2 busy request not taken", 64'(req_ready), 64'd0);
      req_valid = 1'b0;
      rsp_valid = 16'h00F7;
      rsp_hit   = 16'h0001;
      @(negedge clk);
      rsp_valid = '0;
      rsp_hit   = '0;
      chk("R6 directed done", 64'(done_valid && done_hit), 64'd1);
      chk("R6 directed bank", 64'(done_bank), 64'd0);
      chk("R8 directed mig dst", 64'(mig_dst), 64'd1);
      chk("R7 directed no error", 64'(proto_err), 64'd0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL R6 watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule